// File: doc/BRIEF.md
# Dual-Enable Static Memory Core

This block is a synthesizable, clock-sampled model of an 8192-word by 8-bit static memory with a 13-bit address. Two chip selects of opposite polarity gate the whole device. An active-low write strobe and an active-low drive enable choose the operation. The shared bidirectional data bus is split into a data input, a data output and an output-drive flag. A fast internal clock samples all control, address and data inputs, standing in for the asynchronous timing of a discrete part.

A write lasts as long as three conditions hold together: the low-true select is low, the high-true select is high and the write strobe is low. While that overlap lasts, the core holds the most recent address and data it has sampled. When any of the three conditions drops, it commits the held pair to the array. A deselected device does not drive its output, ignores the strobes, reports power-down and keeps its contents.

Top module: `sram_dual_en_core`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits (8192 x 8 by default). Every address from 0 to 8191 can be written and read back.
- R2: When `sel_n` is 1 or `sel` is 0, the device is deselected. In that state `power_down` is 1, `dout_en` is 0, `dout` is 0, and `write_n` and `drive_n` have no effect on the memory.
- R3: When the device is selected with `write_n`=1 and `drive_n`=0, `dout_en` is 1 and `dout` carries the word stored at the sampled address.
- R4: When the device is selected with `write_n`=0, a write is in progress whatever the level of `drive_n`. During the write `dout_en` is 0 and `power_down` is 0.
- R5: When the device is selected with `write_n`=1 and `drive_n`=1, `dout_en` is 0, `dout` is 0 and `power_down` is 0.
- R6: A write ends when `sel_n` rises, when `sel` falls or when `write_n` rises. Each of the three ends the write and commits it. The committed word is readable from the sample that follows the one that ended the overlap.
- R7: The committed address and data are the last ones sampled while the overlap was active. Values presented earlier in the same write are discarded.
- R8: If a chip select goes inactive in the same sample in which `write_n` returns to 1, `dout_en` stays 0 in that sample.
- R9: The memory contents survive any length of deselection.
- R10: After synchronous reset (`rst`=1), the device reports `power_down`=1 and `dout_en`=0, and no write is pending.
- R11: Every output reflects the inputs sampled at the preceding rising clock edge, which is a one-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 13 | Word address |
| sel_n | input | 1 | Chip select, active low |
| sel | input | 1 | Chip select, active high |
| write_n | input | 1 | Write strobe, active low |
| drive_n | input | 1 | Output drive enable, active low |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data to the bus, zero when not driving |
| dout_en | output | 1 | Bus driver enable |
| power_down | output | 1 | High while deselected |

## Verification
A stale overlap flag shows up in one of two ways. Either a write lands twice, or a write never lands at all. Both cases become visible on the first read of that address, which is the sample after the write ends. A corrupt held address or held data surfaces as the wrong word on that same read. Mode decode errors appear at once on `dout_en` and `power_down`, one cycle after the offending inputs. The bench checks every output on every sample against a reference model.

// File: rtl/sram_pkg.sv
package sram_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_READ  = 2'd2,
        MODE_WRITE = 2'd3
    } mode_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic write_n;
        logic drive_n;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{sel_n: 1'b1, sel: 1'b0, write_n: 1'b1, drive_n: 1'b1};

    function automatic mode_e decode_mode(input ctrl_t c);
        if (c.sel_n || !c.sel)
            return MODE_OFF;
        else if (!c.write_n)
            return MODE_WRITE;
        else if (!c.drive_n)
            return MODE_READ;
        else
            return MODE_IDLE;
    endfunction

endpackage

// File: rtl/sram_in_sampler.sv
module sram_in_sampler
    import sram_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output ctrl_t             ctrl_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            ctrl_q <= ctrl_in;
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

endmodule

// File: rtl/sram_write_ctrl.sv
module sram_write_ctrl
    import sram_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data
);

    logic overlap;
    logic overlap_prev;

    assign overlap = (mode == MODE_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            overlap_prev <= 1'b0;
            commit_addr  <= '0;
            commit_data  <= '0;
        end else begin
            overlap_prev <= overlap;
            if (overlap) begin
                commit_addr <= addr_s;
                commit_data <= data_s;
            end
        end
    end

    // A commit fires on the first sample after the overlap has ended.
    assign commit = overlap_prev && !overlap;

    // R7: the held pair changes only while a write overlap is sampled.
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(overlap) && !$past(rst) |-> $stable(commit_addr) && $stable(commit_data));

    // R6: each write produces exactly one single-cycle commit.
    assert_single_commit_R6: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sram_dual_en_core.sv
module sram_dual_en_core
    import sram_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              write_n,
    input  logic              drive_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              power_down
);

    ctrl_t             ctrl_in;
    ctrl_t             ctrl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    mode_e             mode;
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;
    logic [DATA_W-1:0] rd_data;

    assign ctrl_in = '{sel_n: sel_n, sel: sel, write_n: write_n, drive_n: drive_n};

    sram_in_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .ctrl_in (ctrl_in),
        .addr_in (addr),
        .data_in (din),
        .ctrl_q  (ctrl_s),
        .addr_q  (addr_s),
        .data_q  (data_s)
    );

    assign mode = decode_mode(ctrl_s);

    sram_write_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wctrl (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .addr_s      (addr_s),
        .data_s      (data_s),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data)
    );

    sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .wr_en   (commit),
        .wr_addr (commit_addr),
        .wr_data (commit_data),
        .rd_addr (addr_s),
        .rd_data (rd_data)
    );

    assign dout_en    = (mode == MODE_READ);
    assign power_down = (mode == MODE_OFF);
    assign dout       = dout_en ? rd_data : '0;

    // R2: a deselected device never drives the bus.
    assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        power_down |-> !dout_en && (dout == '0));

    // R11: power_down follows the select pins with one cycle of latency.
    assert_pd_latency_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> power_down == $past(sel_n || !sel));

    // R3: the bus is driven only after a sampled read condition.
    assert_drive_needs_read_R3: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> $past(!sel_n && sel && write_n && !drive_n));

    // R8: dropping a select as the strobe rises yields no drive.
    assert_no_glitch_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(sel_n || !sel) |-> !dout_en);

endmodule

// File: tb/sram_dual_en_core_tb.sv
module sram_dual_en_core_tb;

    localparam int AW = 13;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          sel_n, sel, write_n, drive_n;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en, power_down;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [DW-1:0] model [1 << AW];
    logic          m_prev_ov = 1'b0;
    logic [AW-1:0] m_hold_a  = '0;
    logic [DW-1:0] m_hold_d  = '0;

    always #5 clk = ~clk;

    sram_dual_en_core u_dut (
        .clk(clk), .rst(rst), .addr(addr), .sel_n(sel_n), .sel(sel),
        .write_n(write_n), .drive_n(drive_n), .din(din),
        .dout(dout), .dout_en(dout_en), .power_down(power_down)
    );

    // Expected {power_down, dout_en, dout} from the requirements.
    function automatic logic [DW+1:0] expect_out(input logic sn, input logic s,
            input logic wn, input logic dn, input logic [AW-1:0] a);
        if (sn || !s)    return {1'b1, 1'b0, {DW{1'b0}}};   // R2
        if (!wn)         return {1'b0, 1'b0, {DW{1'b0}}};   // R4
        if (!dn)         return {1'b0, 1'b1, model[a]};     // R3
        return {1'b0, 1'b0, {DW{1'b0}}};                    // R5
    endfunction

    task automatic check(input string tag, input logic [DW+1:0] act, input logic [DW+1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual pd/oe/data=%b/%b/%h expected %b/%b/%h",
                     tag, act[DW+1], act[DW], act[DW-1:0], exp[DW+1], exp[DW], exp[DW-1:0]);
        end
    endtask

    // Drive on the falling edge, sample on the next falling edge (R11).
    task automatic step(input string tag, input logic sn, input logic s, input logic wn,
                        input logic dn, input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW+1:0] exp;
        logic          ov;
        sel_n = sn; sel = s; write_n = wn; drive_n = dn; addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
        exp = expect_out(sn, s, wn, dn, a);
        check(tag, {power_down, dout_en, dout}, exp);
        ov = !sn && s && !wn;
        if (m_prev_ov && !ov) model[m_hold_a] = m_hold_d;
        if (ov) begin
            m_hold_a = a;
            m_hold_d = d;
        end
        m_prev_ov = ov;
    endtask

    task automatic write_word(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
        step(tag, 1'b0, 1'b1, 1'b0, 1'b1, a, d);
        step(tag, 1'b0, 1'b1, 1'b1, 1'b1, a, d);
    endtask

    task automatic read_word(input string tag, input logic [AW-1:0] a);
        step(tag, 1'b0, 1'b1, 1'b1, 1'b0, a, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; sel_n = 1'b1; sel = 1'b0; write_n = 1'b1; drive_n = 1'b1;
        addr = '0; din = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check("R10 reset", {power_down, dout_en, dout}, {1'b1, 1'b0, {DW{1'b0}}});
        rst = 1'b0;

        // R1: extreme addresses, plus a known pattern in the random window
        write_word("R1 write low", 13'd0, 8'hA5);
        write_word("R1 write high", 13'd8191, 8'h3C);
        read_word("R1 read low", 13'd0);
        read_word("R1 read high", 13'd8191);
        for (int i = 0; i < 16; i++) write_word("R1 fill", AW'(i), DW'(i * 17 + 3));

        // R4: write with drive enabled, R6 ended by sel_n rising
        step("R4 write drive_n low", 1'b0, 1'b1, 1'b0, 1'b0, 13'd5, 8'h11);
        step("R6 end by sel_n", 1'b1, 1'b1, 1'b0, 1'b0, 13'd5, 8'h11);
        read_word("R6 readback sel_n", 13'd5);

        // R6: ended by sel falling
        step("R4 write", 1'b0, 1'b1, 1'b0, 1'b1, 13'd6, 8'h22);
        step("R6 end by sel", 1'b0, 1'b0, 1'b0, 1'b1, 13'd6, 8'h22);
        read_word("R6 readback sel", 13'd6);

        // R6/R7: ended by write_n rising, data changed mid-write
        step("R7 write first", 1'b0, 1'b1, 1'b0, 1'b1, 13'd7, 8'h01);
        step("R7 write second", 1'b0, 1'b1, 1'b0, 1'b1, 13'd8, 8'h77);
        step("R6 end by write_n as read", 1'b0, 1'b1, 1'b1, 1'b0, 13'd8, 8'h00);
        read_word("R7 last value wins", 13'd8);
        read_word("R7 earlier addr untouched", 13'd7);

        // R8: select drops as write_n rises
        step("R8 write", 1'b0, 1'b1, 1'b0, 1'b0, 13'd9, 8'h99);
        step("R8 drop with strobe", 1'b1, 1'b1, 1'b1, 1'b0, 13'd9, 8'h99);
        read_word("R8 readback", 13'd9);

        // R5: selected idle
        step("R5 idle", 1'b0, 1'b1, 1'b1, 1'b1, 13'd9, 8'h00);

        // R2: strobes while deselected must not write
        step("R2 strobe deselected", 1'b1, 1'b1, 1'b0, 1'b0, 13'd10, 8'hEE);
        step("R2 strobe deselected", 1'b0, 1'b0, 1'b0, 1'b1, 13'd10, 8'hEE);
        step("R2 release", 1'b1, 1'b0, 1'b1, 1'b1, 13'd10, 8'hEE);
        read_word("R2 no write while off", 13'd10);

        // R9: long power-down keeps contents
        for (int i = 0; i < 50; i++) step("R9 power-down", 1'b1, 1'b0, 1'b1, 1'b0, 13'd3, 8'h00);
        read_word("R9 retained", 13'd3);
        read_word("R9 retained high", 13'd8191);

        // Random mix: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 600; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            step("R3 random mix", r[0] & r[1], r[2] | r[3], 1'($urandom), 1'($urandom),
                 AW'($urandom_range(0, 15)), DW'($urandom));
        end
        step("R6 random flush", 1'b1, 1'b0, 1'b1, 1'b1, '0, '0);
        for (int i = 0; i < 16; i++) read_word("R6 random readback", AW'(i));

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule